// File: doc/BRIEF.md
# Sync-Header Bit-Error-Rate Monitor

This block sits in the receive path of a 64b/66b physical coding sublayer. It runs after block alignment has been reached. Each incoming 66-bit block carries a 2-bit synchronisation header. A correct header alternates its two bits. A header whose two bits are equal can only come from line errors. The monitor counts such bad headers over a fixed measurement window. It raises a high-error-rate flag toward the MAC side once the count in one window reaches a threshold of 16 by default.

The window length is a parameter counted in clock cycles. A 125 us window at a 156.25 MHz block clock is 19531 cycles. The flag is set as soon as the threshold is reached, without waiting for the window to end. The flag is cleared at the end of a window that saw fewer errors than the threshold. While the alignment indication is low, the window timer and the error count are held at zero, and the flag keeps its value.

Top module: `ber_monitor`

## Requirements
- R1: While `rst_n` is low, `hi_ber` is 0 and the window timer and error count are zero. Error headers presented during reset have no effect afterwards.
- R2: With `blk_hdr[1:0]`, the values 2'b01 and 2'b10 are valid and are not counted. The values 2'b00 and 2'b11 each count as one error.
- R3: A header is judged only in a cycle where `blk_valid` is 1. Error headers with `blk_valid` at 0 are never counted.
- R4: When the clock edge samples the THRESH-th counted error of a window, `hi_ber` reads 1 right after that same edge. This holds at any point in the window.
- R5: The error count saturates at THRESH. Once set, `hi_ber` stays 1 at least until the end of the next complete window.
- R6: While `blk_lock` is 1, every clock cycle advances the window, and a window lasts WIN_CYC cycles. On the window's last cycle the count returns to zero. If the count stayed below THRESH in that window, `hi_ber` is cleared at that edge.
- R7: While `blk_lock` is 0, the timer and count are held at zero and `hi_ber` keeps its value. Errors seen before lock was lost do not carry into the next window.
- R8: An error on the last cycle of a window belongs to that window. Errors in separate windows never add up toward the threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| blk_valid | input | 1 | A received block is present this cycle |
| blk_hdr | input | 2 | Synchronisation header of the present block |
| blk_lock | input | 1 | Block alignment has been reached |
| hi_ber | output | 1 | High bit-error-rate flag toward the MAC side |

## Verification
The bench drives bad headers of both kinds mixed with good headers of both kinds. A just-below-threshold run shows that valid headers and strobe-less cycles are not counted. A run that reaches the threshold mid-window, followed by extra errors, separates the immediate set from the end-of-window decision and shows saturation. Two error bursts placed on either side of a window boundary show that windows are independent. Dropping lock in the middle of a burst, and again while the flag is set, shows that the count is cleared while the flag is held.

// File: rtl/ber_mon_pkg.sv
`timescale 1ns/1ps
package ber_mon_pkg;

  typedef logic [1:0] sync_hdr_t;

  localparam sync_hdr_t HDR_DATA = 2'b01;
  localparam sync_hdr_t HDR_CTRL = 2'b10;

  // A header is bad when both bits are equal (R2)
  function automatic logic hdr_bad(input sync_hdr_t h);
    return (h != HDR_DATA) && (h != HDR_CTRL);
  endfunction

  // Bits needed to hold values 0..n
  function automatic int unsigned width_for(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/ber_win_timer.sv
`timescale 1ns/1ps
module ber_win_timer #(
  parameter int unsigned WIN_CYC = 19531,
  parameter int unsigned TMR_W   = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic win_end
);

  localparam logic [TMR_W-1:0] LAST = TMR_W'(WIN_CYC - 1);

  logic [TMR_W-1:0] tmr;

  assign win_end = run && (tmr == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tmr <= '0;
    else if (!run)    tmr <= '0;
    else if (win_end) tmr <= '0;
    else              tmr <= tmr + 1'b1;
  end

  a_r7_timer_held: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (tmr == '0));

  a_r6_timer_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |=> (tmr == '0));

  a_r6_timer_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !win_end) |=> (tmr == $past(tmr) + 1'b1));

endmodule

// File: rtl/ber_err_count.sv
`timescale 1ns/1ps
module ber_err_count #(
  parameter int unsigned THRESH = 16,
  parameter int unsigned CNT_W  = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic err_evt,
  input  logic win_end,
  output logic hit
);

  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(THRESH);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_inc;

  // Saturating increment (R5)
  always_comb begin
    cnt_inc = cnt;
    if (err_evt && (cnt != LIMIT)) cnt_inc = cnt + 1'b1;
  end

  assign hit = (cnt_inc == LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (!run)    cnt <= '0;
    else if (win_end) cnt <= '0;
    else              cnt <= cnt_inc;
  end

  a_r5_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cnt <= LIMIT));

  a_r3_quiet_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !win_end && !err_evt) |=> (cnt == $past(cnt)));

  a_r7_count_held: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0));

  a_r8_window_clears: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |=> (cnt == '0));

endmodule

// File: rtl/ber_flag.sv
`timescale 1ns/1ps
module ber_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic hit,
  input  logic win_end,
  output logic hi_ber
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             hi_ber <= 1'b0;
    else if (run) begin
      if (hit)              hi_ber <= 1'b1;
      else if (win_end)     hi_ber <= 1'b0;
    end
  end

  a_r4_set_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (run && hit) |=> hi_ber);

  a_r6_clear_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    (run && win_end && !hit) |=> !hi_ber);

  a_r5_keep_mid_window: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !win_end && hi_ber) |=> hi_ber);

  a_r7_hold_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(hi_ber));

endmodule

// File: rtl/ber_monitor.sv
`timescale 1ns/1ps
module ber_monitor
  import ber_mon_pkg::*;
#(
  parameter int unsigned WIN_CYC = 19531,
  parameter int unsigned THRESH  = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       blk_valid,
  input  logic [1:0] blk_hdr,
  input  logic       blk_lock,
  output logic       hi_ber
);

  localparam int unsigned TMR_W = width_for(WIN_CYC - 1);
  localparam int unsigned CNT_W = width_for(THRESH);

  logic err_evt;
  logic win_end;
  logic hit;

  // Counted error event (R2, R3)
  assign err_evt = blk_lock && blk_valid && hdr_bad(blk_hdr);

  ber_win_timer #(.WIN_CYC(WIN_CYC), .TMR_W(TMR_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (blk_lock),
    .win_end (win_end)
  );

  ber_err_count #(.THRESH(THRESH), .CNT_W(CNT_W)) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (blk_lock),
    .err_evt (err_evt),
    .win_end (win_end),
    .hit     (hit)
  );

  ber_flag u_flag (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (blk_lock),
    .hit     (hit),
    .win_end (win_end),
    .hi_ber  (hi_ber)
  );

  a_r3_no_strobe_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (!blk_valid && !hi_ber && !hit) |=> !hi_ber);

endmodule

// File: tb/test_ber_monitor.sv
`timescale 1ns/1ps
module test_ber_monitor;

  localparam int WIN = 64;
  localparam int TH  = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       blk_valid = 1'b0;
  logic [1:0] blk_hdr = 2'b01;
  logic       blk_lock = 1'b0;
  logic       hi_ber;

  ber_monitor #(.WIN_CYC(WIN), .THRESH(TH)) i_ber_monitor (
    .clk(clk), .rst_n(rst_n), .blk_valid(blk_valid),
    .blk_hdr(blk_hdr), .blk_lock(blk_lock), .hi_ber(hi_ber)
  );

  always #2.5 clk = ~clk;

  typedef struct { logic exp; string tag; } exp_t;
  exp_t q[$];
  exp_t cur;
  int   n_run  = 0;
  int   n_fail = 0;
  bit   done   = 1'b0;

  // Reference state, written from the requirements
  int   m_tmr = 0;
  int   m_cnt = 0;
  logic m_hi  = 1'b0;

  task automatic cyc(input logic r, input logic v, input logic [1:0] h,
                     input logic lk, input string tag);
    logic bad;
    @(negedge clk);
    rst_n = r; blk_valid = v; blk_hdr = h; blk_lock = lk;
    bad = v && (h[1] == h[0]);
    if (!r) begin
      m_tmr = 0; m_cnt = 0; m_hi = 1'b0;
    end else if (!lk) begin
      m_tmr = 0; m_cnt = 0;
    end else begin
      if (bad && m_cnt < TH) m_cnt++;
      if (m_cnt >= TH) m_hi = 1'b1;
      else if (m_tmr == WIN - 1) m_hi = 1'b0;
      if (m_tmr == WIN - 1) begin m_tmr = 0; m_cnt = 0; end
      else m_tmr++;
    end
    q.push_back('{m_hi, tag});
  endtask

  task automatic drv(input logic v, input logic [1:0] h, input string tag);
    cyc(1'b1, v, h, 1'b1, tag);
  endtask

  task automatic to_window_start(input string tag);
    while (m_tmr != 0) drv(1'b1, 2'b01, tag);
  endtask

  task automatic errs(input int n, input logic [1:0] h, input string tag);
    for (int i = 0; i < n; i++) drv(1'b1, h, tag);
  endtask

  // Monitor: compares each result after its clock edge
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      cur = q.pop_front();
      n_run++;
      if (hi_ber !== cur.exp) begin
        n_fail++;
        $display("FAIL %s: hi_ber=%b expected %b at %0t", cur.tag, hi_ber, cur.exp, $time);
      end
    end
  end

  initial begin
    // R1: reset with error headers present
    for (int i = 0; i < 4; i++) cyc(1'b0, 1'b1, 2'b00, 1'b1, "R1 reset");
    // Lock low first: flag held at 0
    for (int i = 0; i < 3; i++) cyc(1'b1, 1'b1, 2'b11, 1'b0, "R7 unlocked start");

    // R2: 15 bad headers mixed with valid ones, no flag
    for (int i = 0; i < 15; i++) begin
      drv(1'b1, (i % 2 == 0) ? 2'b00 : 2'b11, "R2 bad below threshold");
      drv(1'b1, (i % 2 == 0) ? 2'b01 : 2'b10, "R2 valid headers");
    end
    to_window_start("R2 window end");

    // R3: strobe-less error headers are ignored
    for (int i = 0; i < 20; i++) drv(1'b0, 2'b00, "R3 no strobe");
    errs(15, 2'b11, "R3 real errors");
    to_window_start("R3 window end");

    // R4: threshold reached mid-window, flag at once
    drv(1'b1, 2'b01, "R4 lead");
    errs(TH, 2'b11, "R4 threshold");
    // R5: further errors saturate, flag survives window end
    errs(10, 2'b00, "R5 saturate");
    to_window_start("R5 window end");

    // R6: next window with few errors clears the flag at its end
    errs(3, 2'b00, "R6 few errors");
    to_window_start("R6 clear at end");

    // R8: errors split across a boundary do not add up
    while (m_tmr != WIN - 8) drv(1'b1, 2'b10, "R8 approach");
    errs(8, 2'b00, "R8 tail of window");
    errs(8, 2'b11, "R8 head of window");
    to_window_start("R8 window end");
    // R8: last-cycle error counts toward its own window
    while (m_tmr != WIN - TH) drv(1'b1, 2'b10, "R8 approach late");
    errs(TH, 2'b00, "R8 last cycle error");
    to_window_start("R8 late window end");
    to_window_start("R8 late follow");
    drv(1'b1, 2'b01, "R8 step");
    to_window_start("R8 clear");

    // R7: lock loss clears the partial count
    errs(10, 2'b00, "R7 before loss");
    for (int i = 0; i < 5; i++) cyc(1'b1, 1'b1, 2'b11, 1'b0, "R7 unlocked");
    errs(10, 2'b11, "R7 after loss");
    to_window_start("R7 no flag");
    // R7: flag held while unlocked, longer than a window
    errs(TH, 2'b11, "R7 set");
    for (int i = 0; i < WIN + 20; i++) cyc(1'b1, 1'b1, 2'b01, 1'b0, "R7 hold");
    for (int i = 0; i < 2 * WIN + 2; i++) drv(1'b1, 2'b01, "R7 relock clear");

    // R1: reset while the flag is set
    errs(TH, 2'b00, "R1 set before reset");
    for (int i = 0; i < 3; i++) cyc(1'b0, 1'b1, 2'b00, 1'b1, "R1 reset with flag");
    errs(TH - 1, 2'b00, "R1 count cleared by reset");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule